// File: doc/BRIEF.md
# Per-Queue Transmit Rate Pacer

This block holds back transmit queues so that each of them respects an absolute rate limit. Every queue carries a programmable rate factor: the ratio of link speed to target rate, a fixed-point number with a 10-bit integer part and a 14-bit fraction. Each time the transmit path reports that a packet has left a queue, the pacer computes a spacing in link byte-times. The spacing is the packet length times the factor, with the fraction truncated, plus a global compensation term. The queue's eligibility output stays low until that spacing has run out. A separate scheduler picks among eligible queues. That scheduler is not part of this block.

Software programs the block through a small register port. It writes a queue index first. Rate-word writes and the rate-word readback then act on that queue. The register port also carries the compensation value and a clear-all strobe that empties every limiter at once.

Time runs in link byte-times. At 10 Gb/s one byte-time equals one clock. At 1 Gb/s one byte-time equals `SLOW_DIV` clocks. A factor programmed for one speed therefore scales with the link automatically until software reloads it. The block compares timestamps with a signed difference, so the free-running time base may wrap.

Top module: `txq_rate_pacer`

## Requirements
- R1: After reset every rate word reads 0 and every bit of `q_eligible` is 1.
- R2: A write to `rate_wdata` goes to the queue last written through `sel_idx`. `rate_rdata` returns that queue's word exactly as written. Bit 31 is the enable, bits [23:14] are the integer part of the factor and bits [13:0] are its fraction. Other queues keep their words.
- R3: A queue whose enable bit is 0 is always eligible. Packet reports against it have no effect.
- R4: At 10 Gb/s, after a report of length L on an enabled queue, the queue stays ineligible for gap−1 clocks after the report edge, where gap = floor(L × factor) + compensation. Back-to-back reports sent at the first eligible cycle are therefore max(gap,1) clocks apart.
- R5: The compensation value is added once to each packet's spacing.
- R6: With `link_1g`=1 a byte-time lasts `SLOW_DIV` clocks. The same factor then yields a spacing between `SLOW_DIV`×gap−(`SLOW_DIV`−1) and `SLOW_DIV`×gap clocks.
- R7: A `clear_all` pulse sets every rate word to 0, and every queue is eligible from the next cycle on.
- R8: Spacing stays exact across a wrap of the time base. An enabled queue that stays idle for longer than half the time-base range is still eligible.
- R9: A report against one queue leaves the eligibility of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_1g | input | 1 | 1: link runs at 1 Gb/s, 0: at 10 Gb/s |
| sel_we | input | 1 | Write strobe for the queue select |
| sel_idx | input | QW | Queue index to select |
| rate_we | input | 1 | Write strobe for the selected queue's rate word |
| rate_wdata | input | 32 | Rate word: enable in bit 31, factor in bits [23:0] |
| rate_rdata | output | 32 | Rate word of the selected queue |
| comp_we | input | 1 | Write strobe for the compensation value |
| comp_wdata | input | COMP_W | Compensation in byte-times |
| clear_all | input | 1 | Clears every limiter |
| tx_done | input | 1 | Packet-departure report strobe |
| tx_qidx | input | QW | Queue that sent the packet |
| tx_len | input | LEN_W | Packet length in bytes |
| q_eligible | output | NQ | Per-queue may-transmit flags |

## Verification
A register write is sampled at a rising edge, and its readback is compared at the falling edge that follows. At 10 Gb/s a packet report updates the queue's timestamp at its sampling edge. The eligibility output falls right after that edge and comes back gap−1 edges later. The bench therefore sends each next packet at the first falling edge where the queue is eligible and compares the edge-count difference with max(gap,1) exactly. At 1 Gb/s the phase of the byte-time divider is not visible at the ports, so the spacing is checked against a window of `SLOW_DIV` clocks. The effect of a clear-all is checked at the first falling edge after its edge.

// File: rtl/txq_pacer_pkg.sv
package txq_pacer_pkg;
   localparam int WORD_W = 32;
   localparam int FRAC_W = 14;
   localparam int INT_W  = 10;
   localparam int FAC_W  = FRAC_W + INT_W;
   localparam int EN_BIT = 31;

   typedef logic [FAC_W-1:0]  factor_t;
   typedef logic [WORD_W-1:0] rword_t;

   function automatic factor_t word_factor(input rword_t w);
      return w[FAC_W-1:0];
   endfunction

   function automatic logic word_enable(input rword_t w);
      return w[EN_BIT];
   endfunction
endpackage

// File: rtl/txq_rate_timebase.sv
module txq_rate_timebase #(
   parameter int TS_W     = 32,
   parameter int SLOW_DIV = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow,
   output logic            tick,
   output logic [TS_W-1:0] now
);
   localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

   generate
      if (SLOW_DIV > 1) begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !slow)
               div_q <= '0;
            else if (div_q == DIV_W'(SLOW_DIV - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign tick = !slow || (div_q == DIV_W'(SLOW_DIV - 1));
      end else begin : g_nodiv
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         now <= '0;
      else if (tick)
         now <= now + 1'b1;
   end
endmodule

// File: rtl/txq_rate_gap.sv
module txq_rate_gap
   import txq_pacer_pkg::*;
#(
   parameter int LEN_W  = 14,
   parameter int COMP_W = 10,
   parameter int GAP_W  = 25
) (
   input  logic [LEN_W-1:0]  len,
   input  factor_t           factor,
   input  logic [COMP_W-1:0] comp,
   output logic [GAP_W-1:0]  gap
);
   localparam int PROD_W = LEN_W + FAC_W;

   logic [PROD_W-1:0] prod;

   always_comb begin
      prod = PROD_W'(len) * PROD_W'(factor);
      gap  = GAP_W'(prod >> FRAC_W) + GAP_W'(comp);
   end
endmodule

// File: rtl/txq_rate_slot.sv
module txq_rate_slot
   import txq_pacer_pkg::*;
#(
   parameter int TS_W  = 32,
   parameter int GAP_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr_en,
   input  rword_t           wr_word,
   input  logic [TS_W-1:0]  now,
   input  logic             launch,
   input  logic [GAP_W-1:0] gap,
   output rword_t           word,
   output logic             eligible
);
   logic [TS_W-1:0] ts_q;
   logic            en;

   assign en       = word_enable(word);
   assign eligible = !en || ($signed(now - ts_q) >= 0);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         word <= '0;
      else if (wr_en)
         word <= wr_word;
   end

   // timestamp follows the time base unless a spacing is pending
   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         ts_q <= now;
      else if (en && launch)
         ts_q <= now + TS_W'(gap);
      else if (eligible)
         ts_q <= now;
   end
endmodule

// File: rtl/txq_rate_pacer.sv
module txq_rate_pacer
   import txq_pacer_pkg::*;
#(
   parameter int NQ       = 8,
   parameter int LEN_W    = 14,
   parameter int COMP_W   = 10,
   parameter int TS_W     = 32,
   parameter int SLOW_DIV = 10,
   localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_1g,
   input  logic              sel_we,
   input  logic [QW-1:0]     sel_idx,
   input  logic              rate_we,
   input  logic [31:0]       rate_wdata,
   output logic [31:0]       rate_rdata,
   input  logic              comp_we,
   input  logic [COMP_W-1:0] comp_wdata,
   input  logic              clear_all,
   input  logic              tx_done,
   input  logic [QW-1:0]     tx_qidx,
   input  logic [LEN_W-1:0]  tx_len,
   output logic [NQ-1:0]     q_eligible
);
   localparam int SCALED_W = LEN_W + INT_W;
   localparam int GAP_W    = ((SCALED_W > COMP_W) ? SCALED_W : COMP_W) + 1;

   generate
      if (NQ < 2) begin : g_bad_nq
         $error("txq_rate_pacer: NQ must be at least 2");
      end
      if (TS_W <= GAP_W) begin : g_bad_ts
         $error("txq_rate_pacer: TS_W must exceed the spacing width");
      end
      if (SLOW_DIV < 1) begin : g_bad_div
         $error("txq_rate_pacer: SLOW_DIV must be positive");
      end
   endgenerate

   logic [QW-1:0]         sel_q;
   logic [COMP_W-1:0]     comp_q;
   logic                  tick;
   logic [TS_W-1:0]       now;
   rword_t                words [NQ];
   logic [NQ-1:0]         en_vec;
   logic [NQ*FAC_W-1:0]   fac_flat;
   factor_t               tx_fac;
   logic [GAP_W-1:0]      gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         comp_q <= '0;
      end else begin
         if (sel_we)  sel_q  <= sel_idx;
         if (comp_we) comp_q <= comp_wdata;
      end
   end

   txq_rate_timebase #(.TS_W(TS_W), .SLOW_DIV(SLOW_DIV)) u_tb (
      .clk(clk), .rst_n(rst_n), .slow(link_1g), .tick(tick), .now(now)
   );

   always_comb begin
      tx_fac = '0;
      for (int k = 0; k < NQ; k++)
         if (tx_qidx == QW'(k)) tx_fac = word_factor(words[k]);
   end

   txq_rate_gap #(.LEN_W(LEN_W), .COMP_W(COMP_W), .GAP_W(GAP_W)) u_gap (
      .len(tx_len), .factor(tx_fac), .comp(comp_q), .gap(gap)
   );

   generate
      for (genvar i = 0; i < NQ; i++) begin : g_q
         txq_rate_slot #(.TS_W(TS_W), .GAP_W(GAP_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clear(clear_all),
            .wr_en(rate_we && (sel_q == QW'(i))),
            .wr_word(rate_wdata), .now(now),
            .launch(tx_done && (tx_qidx == QW'(i))),
            .gap(gap), .word(words[i]), .eligible(q_eligible[i])
         );
         assign en_vec[i] = word_enable(words[i]);
         assign fac_flat[i*FAC_W +: FAC_W] = word_factor(words[i]);
      end
   endgenerate

   always_comb begin
      rate_rdata = '0;
      for (int k = 0; k < NQ; k++)
         if (sel_q == QW'(k)) rate_rdata = words[k];
   end
endmodule

module txq_rate_pacer_chk #(
   parameter int NQ = 8,
   parameter int QW = 3,
   parameter int LEN_W = 14,
   parameter int FAC_W = 24,
   parameter int FRAC_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_1g,
   input logic              sel_we,
   input logic              rate_we,
   input logic [31:0]       rate_wdata,
   input logic [31:0]       rate_rdata,
   input logic              clear_all,
   input logic              tx_done,
   input logic [QW-1:0]     tx_qidx,
   input logic [LEN_W-1:0]  tx_len,
   input logic [NQ-1:0]     q_eligible,
   input logic [NQ-1:0]     en_vec,
   input logic [NQ*FAC_W-1:0] fac_flat,
   input logic              tick
);
   generate
      for (genvar i = 0; i < NQ; i++) begin : g_dis
         // R3
         disabled_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[i] |-> q_eligible[i]);
      end
   endgenerate

   // R7
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> (q_eligible == {NQ{1'b1}}) && (en_vec == '0));

   // R2
   rate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_we && !sel_we && !clear_all) |=> rate_rdata == $past(rate_wdata));

   // R4
   launch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && (int'(tx_qidx) < NQ) && en_vec[tx_qidx] && (tx_len != '0)
       && (fac_flat[int'(tx_qidx)*FAC_W + FRAC_W +: 10] >= 10'd2)
       && !clear_all && !rate_we)
      |=> !q_eligible[$past(tx_qidx)]);

   // R6
   fast_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_1g |-> tick);

   // R6
   slow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_1g && tick) |=> (!link_1g || !tick));
endmodule

bind txq_rate_pacer txq_rate_pacer_chk #(
   .NQ(NQ), .QW(QW), .LEN_W(LEN_W),
   .FAC_W(txq_pacer_pkg::FAC_W), .FRAC_W(txq_pacer_pkg::FRAC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .link_1g(link_1g), .sel_we(sel_we),
   .rate_we(rate_we), .rate_wdata(rate_wdata), .rate_rdata(rate_rdata),
   .clear_all(clear_all), .tx_done(tx_done), .tx_qidx(tx_qidx),
   .tx_len(tx_len), .q_eligible(q_eligible), .en_vec(en_vec),
   .fac_flat(fac_flat), .tick(tick)
);

// File: tb/txq_rate_pacer_tb.sv
module txq_rate_pacer_tb;
   localparam int NQ = 4;
   localparam int QW = 2;
   localparam int LEN_W = 4;
   localparam int COMP_W = 10;
   localparam int TS_W = 16;
   localparam int DIV = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_1g = 1'b0;
   logic sel_we = 1'b0;
   logic [QW-1:0] sel_idx = '0;
   logic rate_we = 1'b0;
   logic [31:0] rate_wdata = '0;
   logic [31:0] rate_rdata;
   logic comp_we = 1'b0;
   logic [COMP_W-1:0] comp_wdata = '0;
   logic clear_all = 1'b0;
   logic tx_done = 1'b0;
   logic [QW-1:0] tx_qidx = '0;
   logic [LEN_W-1:0] tx_len = '0;
   logic [NQ-1:0] elig;

   int errors = 0;
   int checks = 0;
   longint cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   txq_rate_pacer #(.NQ(NQ), .LEN_W(LEN_W), .COMP_W(COMP_W), .TS_W(TS_W),
                    .SLOW_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .link_1g(link_1g), .sel_we(sel_we),
      .sel_idx(sel_idx), .rate_we(rate_we), .rate_wdata(rate_wdata),
      .rate_rdata(rate_rdata), .comp_we(comp_we), .comp_wdata(comp_wdata),
      .clear_all(clear_all), .tx_done(tx_done), .tx_qidx(tx_qidx),
      .tx_len(tx_len), .q_eligible(elig)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   function automatic longint gap_of(input int len, input logic [31:0] w, input int comp);
      return ((longint'(len) * longint'(w[23:0])) >> 14) + comp;
   endfunction

   task automatic sel(input int q);
      sel_we = 1'b1; sel_idx = QW'(q); @(negedge clk); sel_we = 1'b0;
   endtask

   task automatic prog(input int q, input logic [31:0] w);
      sel(q);
      rate_we = 1'b1; rate_wdata = w; @(negedge clk); rate_we = 1'b0;
   endtask

   task automatic set_comp(input int c);
      comp_we = 1'b1; comp_wdata = COMP_W'(c); @(negedge clk); comp_we = 1'b0;
   endtask

   task automatic send(input int q, input int len, output longint t);
      while (!elig[q]) @(negedge clk);
      t = cyc;
      tx_done = 1'b1; tx_qidx = QW'(q); tx_len = LEN_W'(len);
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   localparam logic [31:0] FACS [4] = '{32'h8000_4000, 32'h8000_A000,
                                        32'h800A_6AAB, 32'h8001_E555};

   initial begin
      longint t0, t1;
      int comp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 eligible", elig, 4'hF);
      for (int q = 0; q < NQ; q++) begin
         sel(q);
         chk("R1 word", rate_rdata, 0);
      end

      // R2 indirect access and readback
      prog(1, 32'hFF0A_6AAB);
      chk("R2 readback", rate_rdata, 32'hFF0A_6AAB);
      prog(2, 32'h8000_A000);
      chk("R2 q2", rate_rdata, 32'h8000_A000);
      sel(1);
      chk("R2 q1 kept", rate_rdata, 32'hFF0A_6AAB);
      sel(3);
      chk("R2 q3 untouched", rate_rdata, 0);

      // R4 sweep over factors and lengths, comp = 4
      comp = 4;
      set_comp(comp);
      for (int f = 0; f < 4; f++) begin
         int prev;
         prog(1, FACS[f]);
         prev = 1;
         send(1, prev, t0);
         for (int len = 1; len < 16; len++) begin
            longint g;
            send(1, len, t1);
            g = gap_of(prev, FACS[f], comp);
            chk($sformatf("R4 f%0d len%0d", f, prev), t1 - t0, (g < 1) ? 1 : g);
            t0 = t1;
            prev = len;
         end
      end

      // R9 other queues unaffected by a report on q1
      prog(1, 32'h800A_6AAB);
      send(1, 15, t0);
      chk("R9 q1 blocked", elig[1], 0);
      chk("R9 q2 free", elig[2], 1);
      chk("R9 q0 free", elig[0], 1);

      // R5 compensation added once
      prog(3, 32'h8000_4000);
      set_comp(0);
      send(3, 10, t0); send(3, 10, t1);
      chk("R5 comp 0", t1 - t0, 10);
      set_comp(20);
      send(3, 10, t0); send(3, 10, t1);
      chk("R5 comp 20", t1 - t0, 30);
      comp = 4;
      set_comp(comp);

      // R3 disabled queues never held back
      prog(0, 32'h0320_0000);
      for (int k = 0; k < 3; k++) begin
         tx_done = 1'b1; tx_qidx = 2'd0; tx_len = 4'd15;
         @(negedge clk);
         tx_done = 1'b0;
         chk("R3 disabled eligible", elig[0], 1);
      end
      sel(0);
      chk("R3 word unchanged", rate_rdata, 32'h0320_0000);

      // R6 1 Gb/s: byte-time is DIV clocks
      link_1g = 1'b1;
      prog(2, 32'h8000_A000);
      send(2, 15, t0);
      for (int k = 0; k < 3; k++) begin
         longint g;
         send(2, 15, t1);
         g = gap_of(15, 32'h8000_A000, comp);
         chk_rng("R6 slow spacing", t1 - t0, DIV * g - (DIV - 1), DIV * g);
         t0 = t1;
      end
      link_1g = 1'b0;
      @(negedge clk);
      send(2, 15, t0); send(2, 15, t1);
      chk("R6 fast again", t1 - t0, gap_of(15, 32'h8000_A000, comp));

      // R8 wrap of the 16-bit time base
      prog(2, 32'h8032_0000);
      send(2, 15, t0);
      for (int k = 0; k < 24; k++) begin
         send(2, 15, t1);
         chk("R8 wrap spacing", t1 - t0, gap_of(15, 32'h8032_0000, comp));
         t0 = t1;
      end
      repeat (34000) @(negedge clk);
      chk("R8 idle eligible", elig[2], 1);

      // R7 clear-all
      send(2, 15, t0);
      chk("R7 blocked before", elig[2], 0);
      clear_all = 1'b1;
      @(negedge clk);
      clear_all = 1'b0;
      chk("R7 all eligible", elig, 4'hF);
      for (int q = 0; q < NQ; q++) begin
         sel(q);
         chk("R7 word zero", rate_rdata, 0);
      end

      finish_run();
   end
endmodule